// File: doc/BRIEF.md
# Bus Address Space Decoder

This block turns the address and strobes of a small 8-bit-style system bus into chip enables. The address is 16 bits wide. Memory and I/O transactions are told apart by two separate request strobes, and read and write strobes qualify them. From these signals the block drives four outputs: an enable for the main RAM, an enable for a memory-mapped device that sits in the top quarter of the address space, an enable for a single I/O port device, and a flag that marks a memory access landing on an address with nothing behind it.

Decoding is partial. Only the top two address lines pick out the device window. Only address line 0 picks out the port device. All other lines are ignored.

A one-bit shadow register controls the window. When it is set, the window belongs to the device. When it is clear, the window falls through to the RAM behind it, if the build includes RAM there; otherwise such an access raises the unused flag. An I/O write to any odd port loads the register from data bit 0. Every output is registered, so each one reflects the bus cycle seen on the previous clock edge.

Top module: `addr_dec`

## Requirements
- R1: While rstN is low, and in the first cycle after it is released, all four outputs are 0. The shadow register resets to 1, which means the device owns the window.
- R2: If neither request strobe is high, or if memReq and ioReq are both high, no output is asserted and the shadow register keeps its value.
- R3: A memory cycle is one with memReq=1 and ioReq=0. If addr[15] and addr[14] are both 1 and the shadow is 1, the cycle asserts devSel and nothing else. No other address bit affects this result.
- R4: A memory cycle with addr[15] and addr[14] not both 1 asserts ramSel only. A memory cycle that goes to the device leaves ramSel low.
- R5: An I/O cycle is one with ioReq=1 and memReq=0. An I/O cycle never asserts ramSel, devSel or unusedHit, whatever the address.
- R6: portSel is asserted only for an I/O cycle with rdStrobe=1 and addr[0]=0, whatever the other address bits are. An I/O write to an even port asserts nothing and leaves the shadow unchanged.
- R7: An I/O cycle with wrStrobe=1 and addr[0]=1 loads the shadow register from wrData[0]. The new value governs every memory cycle presented after that edge.
- R8: With RAM_BEHIND_WIN=1 and the shadow at 0, a memory cycle in the window asserts ramSel only.
- R9: With RAM_BEHIND_WIN=0 and the shadow at 0, a memory cycle in the window asserts unusedHit only.
- R10: Each output reflects the inputs sampled at the previous rising edge, and at most one output is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Bus address |
| wrData | input | 8 | Bus write data (bit 0 loads the shadow) |
| memReq | input | 1 | Memory request strobe |
| ioReq | input | 1 | I/O request strobe |
| rdStrobe | input | 1 | Read strobe |
| wrStrobe | input | 1 | Write strobe |
| ramSel | output | 1 | RAM enable, registered |
| devSel | output | 1 | Window device enable, registered |
| portSel | output | 1 | Port device enable, registered |
| unusedHit | output | 1 | Access to an address with nothing behind it, registered |

## Verification
The assertions compare each registered enable with the bus inputs one cycle earlier. They take for granted that those inputs are stable and known from the first cycle after reset, and that a strobe clash is simply a cycle in which nothing is selected. The bench therefore drives every input from a defined idle value while reset is held. It then sweeps all sixteen strobe combinations, including the illegal case with both request strobes high, over a set of addresses chosen at the window and port-bit boundaries. Shadow writes happen during the sweep itself, so the sweep reaches both shadow states.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  typedef struct packed {
    logic ramHit;
    logic devHit;
    logic portHit;
    logic unusedHit;
    logic shadowWr;
  } decStrobes_t;
endpackage

// File: rtl/addr_dec_ctrl.sv
module addr_dec_ctrl
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_BITS = 2,
  parameter bit RAM_BEHIND_WIN = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              memReq,
  input  logic              ioReq,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic              shadowOn,
  output decStrobes_t       strobes
);
  localparam int WIN_LSB = ADDR_W - WIN_BITS;

  logic memCyc, ioCyc, inWin, oddPort;

  always_comb begin
    memCyc  = memReq & ~ioReq;
    ioCyc   = ioReq & ~memReq;
    inWin   = &addr[ADDR_W-1:WIN_LSB];
    oddPort = addr[0];

    strobes.devHit    = memCyc & inWin & shadowOn;
    strobes.ramHit    = memCyc & (~inWin | (~shadowOn & RAM_BEHIND_WIN));
    strobes.unusedHit = memCyc & inWin & ~shadowOn & ~RAM_BEHIND_WIN;
    strobes.portHit   = ioCyc & rdStrobe & ~oddPort;
    strobes.shadowWr  = ioCyc & wrStrobe & oddPort;
  end
endmodule

// File: rtl/addr_dec_dp.sv
module addr_dec_dp
  import addr_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  decStrobes_t strobes,
  input  logic        wrBit,
  output logic        shadowOn,
  output logic        ramSel,
  output logic        devSel,
  output logic        portSel,
  output logic        unusedHit
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowOn  <= 1'b1;
      ramSel    <= 1'b0;
      devSel    <= 1'b0;
      portSel   <= 1'b0;
      unusedHit <= 1'b0;
    end else begin
      if (strobes.shadowWr) shadowOn <= wrBit;
      ramSel    <= strobes.ramHit;
      devSel    <= strobes.devHit;
      portSel   <= strobes.portHit;
      unusedHit <= strobes.unusedHit;
    end
  end

  // R10: the registered enables never overlap
  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ramSel, devSel, portSel, unusedHit}));

  // R7: the shadow changes only on a shadow write
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shadowWr |=> $stable(shadowOn));
endmodule

// File: rtl/addr_dec.sv
module addr_dec
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WIN_BITS = 2,
  parameter bit RAM_BEHIND_WIN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              memReq,
  input  logic              ioReq,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  output logic              ramSel,
  output logic              devSel,
  output logic              portSel,
  output logic              unusedHit
);
  decStrobes_t strobes;
  logic shadowOn;

  addr_dec_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .RAM_BEHIND_WIN(RAM_BEHIND_WIN)
  ) u_ctrl (
    .addr(addr), .memReq(memReq), .ioReq(ioReq), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .shadowOn(shadowOn), .strobes(strobes)
  );

  addr_dec_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrBit(wrData[0]),
    .shadowOn(shadowOn), .ramSel(ramSel), .devSel(devSel),
    .portSel(portSel), .unusedHit(unusedHit)
  );

  // R2: a strobe clash selects nothing
  assert_clash_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && ioReq) |=> !(ramSel || devSel || portSel || unusedHit));

  // R6: the port enable needs an even I/O read
  assert_port_R6: assert property (@(posedge clk) disable iff (!rstN)
    portSel |-> $past(ioReq && !memReq && rdStrobe && !addr[0]));

  // R5: RAM and the device only answer memory cycles
  assert_mem_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ramSel || devSel) |-> $past(memReq && !ioReq));

  // R3: the device only answers inside the window
  assert_dev_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    devSel |-> $past(&addr[ADDR_W-1:ADDR_W-WIN_BITS]));

  // R4: an out-of-window memory cycle goes to RAM
  assert_ram_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !ioReq && !(&addr[ADDR_W-1:ADDR_W-WIN_BITS])) |=> ramSel);
endmodule

// File: tb/addr_dec_tb.sv
module addr_dec_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wrData = '0;
  logic memReq = 1'b0, ioReq = 1'b0, rdStrobe = 1'b0, wrStrobe = 1'b0;
  logic ramA, devA, portA, unA;
  logic ramB, devB, portB, unB;
  int checks = 0;
  int failures = 0;
  logic modelShadow = 1'b1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_dec u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .memReq(memReq),
    .ioReq(ioReq), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .ramSel(ramA), .devSel(devA), .portSel(portA), .unusedHit(unA)
  );

  addr_dec #(.RAM_BEHIND_WIN(1'b0)) u_dutNoRam (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .memReq(memReq),
    .ioReq(ioReq), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .ramSel(ramB), .devSel(devB), .portSel(portB), .unusedHit(unB)
  );

  // {ram, dev, port, unused}
  function automatic logic [3:0] expOut(logic [15:0] a, logic m, logic i,
                                        logic r, logic sh, logic ramBehind);
    logic win;
    win = a[15] & a[14];
    if (m && !i) begin
      if (!win) return 4'b1000;
      if (sh) return 4'b0100;
      return ramBehind ? 4'b1000 : 4'b0001;
    end
    if (i && !m && r && !a[0]) return 4'b0010;
    return 4'b0000;
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b addr=%h mem=%b io=%b rd=%b wr=%b",
               tag, act, exp, addr, memReq, ioReq, rdStrobe, wrStrobe);
    end
  endtask

  function automatic string tagOf(logic [15:0] a, logic m, logic i,
                                  logic sh, bit noRam);
    if (m == i) return "R2";
    if (i) return "R5,R6";
    if (!(a[15] & a[14])) return "R4";
    if (sh) return "R3";
    return noRam ? "R9" : "R8";
  endfunction

  // drive at negedge, result checked at the following negedge
  task automatic cycle(logic [15:0] a, logic [7:0] d, logic m, logic i,
                       logic r, logic w);
    logic [3:0] eA, eB;
    string tA, tB;
    addr = a; wrData = d; memReq = m; ioReq = i; rdStrobe = r; wrStrobe = w;
    eA = expOut(a, m, i, r, modelShadow, 1'b1);
    eB = expOut(a, m, i, r, modelShadow, 1'b0);
    tA = tagOf(a, m, i, modelShadow, 1'b0);
    tB = tagOf(a, m, i, modelShadow, 1'b1);
    if (i && !m && w && a[0]) modelShadow = d[0];
    @(negedge clk);
    check({tA, " R10"}, {ramA, devA, portA, unA}, eA);
    check({tB, " R10"}, {ramB, devB, portB, unB}, eB);
  endtask

  initial begin
    logic [15:0] addrs [12];
    addrs = '{16'h0000, 16'h3FFF, 16'h4000, 16'h8001, 16'hBFFF, 16'hC000,
              16'hC001, 16'hFFFE, 16'hFFFF, 16'h00FE, 16'h00FF, 16'h7FFE};
    repeat (3) @(negedge clk);
    check("R1 reset", {ramA, devA, portA, unA}, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {ramA, devA, portA, unA}, 4'b0000);
    // R1: reset shadow is 1, so the window goes to the device
    cycle(16'hC000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R1 shadow reset", {ramA, devA}, 2'b01);

    // R7: clear the shadow via odd port 0x01, then RAM shows through
    cycle(16'h0001, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    cycle(16'hD123, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R7 shadow cleared", {ramA, devA, unB}, 3'b101);
    // R6: an even-port write leaves the shadow alone
    cycle(16'h00FE, 8'h01, 1'b0, 1'b1, 1'b0, 1'b1);
    cycle(16'hFFFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R6 even write no effect", {ramA, devA}, 2'b10);
    // R2: a clashing write to an odd port is ignored
    cycle(16'h0003, 8'h01, 1'b1, 1'b1, 1'b0, 1'b1);
    cycle(16'hC000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R2 clash write no effect", {ramA, devA}, 2'b10);
    // R7: set the shadow again via odd port 0x7F
    cycle(16'h007F, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1);
    cycle(16'hE000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R7 shadow set", {ramA, devA}, 2'b01);
    // R10: output returns to idle one cycle after the bus does
    cycle(16'hE000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 idle", {ramA, devA, portA, unA}, 4'b0000);

    for (int pass = 0; pass < 2; pass++)
      for (int ai = 0; ai < 12; ai++)
        for (int s = 0; s < 16; s++)
          for (int d = 0; d < 2; d++)
            cycle(addrs[ai] ^ 16'(pass), 8'(d ^ pass), s[3], s[2], s[1], s[0]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule